// File: doc/BRIEF.md
# Two-Wire Pointer-Register Slave

This block is a two-wire serial slave that runs entirely on a fast system clock. It oversamples the clock and data lines and detects START, STOP and repeated START conditions. It answers one 7-bit device address, whose upper four bits are fixed at `1110` and whose lower three bits come from strap inputs. An internal 8-bit pointer selects one of a small bank of 8-bit registers. A write transaction loads the pointer and can then write data. A read transaction returns the register that the last written pointer selects.

The block also acts on two special first bytes. The all-zero general call address with a write direction is acknowledged, and a following reset command restores the pointer and the whole register bank. A high-speed master code is never acknowledged, but it raises a flag for the surrounding filters, and the flag holds until the next STOP. The block drives only an open-drain pull-down enable for the data line. It never touches the clock line.

Top module: `tws_ptr_slave`

## Requirements
- R1: After reset, `sda_oe_o`, `hs_mode_o`, `gc_reset_o` and `wr_en_o` are 0. The pointer is 0, and register k holds byte k of `REG_INIT` (default 0xA5, 0x5A, 0x96, 0xC3 for registers 0 to 3).
- R2: The slave only pulls SDA low (`sda_oe_o`=1 means drive 0). It never drives SCL. `sda_oe_o` changes only while the synchronised SCL is low.
- R3: The first byte after START is received MSB first. The upper 7 bits are the address and bit 0 is the direction (1 = read). The address matches when it equals `1110` followed by `addr_sel_i[2:0]`. A match is acknowledged. A mismatch is not acknowledged, and all further bytes are ignored until the next START.
- R4: In a write, the first byte after the address loads the pointer and is acknowledged. Each later byte is acknowledged and written to the selected register. Each such write produces a one-cycle `wr_en_o` pulse carrying `wr_idx_o` and `wr_data_o`. The pointer does not advance, so a second data byte overwrites the same register.
- R5: A write that stops after the pointer byte is legal. It changes only the pointer and produces no `wr_en_o` pulse.
- R6: A read sends the selected register MSB first. The pointer is kept across any number of reads. A master ACK (0) makes the slave send the same register again. A master NACK (1) makes it release SDA and wait for START.
- R7: For pointer values of `NUM_REGS` or above, reads return 0x00. Data bytes are still acknowledged, but they change no register and raise no `wr_en_o`.
- R8: Address byte 0x00 (general call, write) is acknowledged, and so is the command byte that follows it. Command 0x06 gives a one-cycle `gc_reset_o` pulse and restores the pointer and the registers to their R1 values. Any other command has no effect. Address byte 0x01 (general call, read) is not acknowledged.
- R9: A first byte of the form `00001xxx` is not acknowledged and sets `hs_mode_o`. The flag survives repeated START and clears on STOP.
- R10: A repeated START at any bit aborts the byte in progress, leaves the pointer and the registers unchanged, and restarts address reception.
- R11: A STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| addr_sel_i | input | 3 | Strap value for the low three address bits |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| wr_en_o | output | 1 | One-cycle pulse when a register is written |
| wr_idx_o | output | IDX_W | Index of the register written |
| wr_data_o | output | 8 | Byte written |
| gc_reset_o | output | 1 | One-cycle pulse on a general call reset command |
| hs_mode_o | output | 1 | High-speed filter mode flag |

## Verification
The bench targets the places where a slave like this usually slips. A pointer-only write that wrongly commits a data byte would show up as a stray write pulse or a changed read value. A pointer that advances would make repeated read or write bytes hit the wrong register. An unaddressed slave that still acknowledges later bytes would pull SDA during traffic meant for another device. A general call read that is acknowledged, or a command other than reset that clears the bank, would also be caught.

It also covers a repeated START that lands in the middle of a data byte and must not commit it. It drives a high-speed code, where a flag that fails to survive a repeated START or to drop at STOP would be exposed. It uses out-of-range pointers, which must read zero and leave the bank untouched.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_PTR, ST_DATA, ST_GCMD,
    ST_TX, ST_TXEND, ST_MACK, ST_TXLOAD
  } tws_state_e;

  localparam logic [3:0] DEV_PREFIX   = 4'b1110;
  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] GC_RESET_CMD = 8'h06;
  localparam logic [4:0] HS_CODE      = 5'b00001;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= d_i[i];
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/tws_evt.sv
module tws_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // conditions only count while SCL is stable high
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/tws_regbank.sv
module tws_regbank #(
  parameter int                      NUM_REGS = 4,
  parameter int                      IDX_W    = 2,
  parameter logic [NUM_REGS*8-1:0]   REG_INIT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rdata_o
);
  logic [NUM_REGS*8-1:0] flat;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                               r_q <= REG_INIT[g*8 +: 8];
      else if (clr_i)                            r_q <= REG_INIT[g*8 +: 8];
      else if (we_i && idx_i == IDX_W'(g))       r_q <= wdata_i;
    assign flat[g*8 +: 8] = r_q;
  end

  assign rdata_o = flat[rd_idx_i*8 +: 8];
endmodule

// File: rtl/tws_ptr_slave.sv
module tws_ptr_slave #(
  parameter int                    NUM_REGS = 4,
  parameter int                    SYNC_STG = 2,
  parameter logic [NUM_REGS*8-1:0] REG_INIT = 32'hC3_96_5A_A5,
  localparam int                   IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [2:0]       addr_sel_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             gc_reset_o,
  output logic             hs_mode_o
);
  import tws_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  tws_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  tws_evt u_evt (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  tws_state_e st_q, nxt_q;
  logic [2:0] cnt_q;
  logic [6:0] sh_q, tx_q;
  logic [7:0] ptr_q, wr_data_q, bank_rd;
  logic       ack_on_q, oe_q, hs_q, wr_en_q, gc_q;

  logic [7:0] rx_byte, rd_byte;
  logic       last_bit, ptr_ok;

  assign rx_byte  = {sh_q, sda_s};
  assign last_bit = (cnt_q == 3'd7);
  assign ptr_ok   = (ptr_q < 8'(NUM_REGS));
  assign rd_byte  = ptr_ok ? bank_rd : 8'h00;

  tws_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .REG_INIT(REG_INIT)) u_bank (
    .clk_i, .rst_ni, .clr_i(gc_q), .we_i(wr_en_q), .idx_i(ptr_q[IDX_W-1:0]),
    .wdata_i(wr_data_q), .rd_idx_i(ptr_q[IDX_W-1:0]), .rdata_o(bank_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      wr_data_q <= '0;
      ack_on_q  <= 1'b0;
      oe_q      <= 1'b0;
      hs_q      <= 1'b0;
      wr_en_q   <= 1'b0;
      gc_q      <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      gc_q    <= 1'b0;
      if (stop_evt) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
        hs_q <= 1'b0;
      end else if (start_evt) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        oe_q     <= 1'b0;
        ack_on_q <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_PTR, ST_DATA, ST_GCMD: if (scl_rise) begin
            sh_q  <= rx_byte[6:0];
            cnt_q <= cnt_q + 3'd1;
            if (last_bit) begin
              st_q     <= ST_IDLE;  // no ACK unless chosen below
              ack_on_q <= 1'b0;
              case (st_q)
                ST_ADDR: begin
                  if (rx_byte[7:3] == HS_CODE) begin
                    hs_q <= 1'b1;
                  end else if (rx_byte[7:1] == {DEV_PREFIX, addr_sel_i}) begin
                    st_q  <= ST_ACK;
                    nxt_q <= rx_byte[0] ? ST_TX : ST_PTR;
                  end else if (rx_byte == GC_ADDR_BYTE) begin
                    st_q  <= ST_ACK;
                    nxt_q <= ST_GCMD;
                  end
                end
                ST_PTR: begin
                  ptr_q <= rx_byte;
                  st_q  <= ST_ACK;
                  nxt_q <= ST_DATA;
                end
                ST_DATA: begin
                  wr_en_q   <= ptr_ok;
                  wr_data_q <= rx_byte;
                  st_q      <= ST_ACK;
                  nxt_q     <= ST_DATA;
                end
                default: begin  // ST_GCMD
                  if (rx_byte == GC_RESET_CMD) begin
                    gc_q  <= 1'b1;
                    ptr_q <= '0;
                  end
                  st_q  <= ST_ACK;
                  nxt_q <= ST_IDLE;
                end
              endcase
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_on_q) begin
              ack_on_q <= 1'b1;
              oe_q     <= 1'b1;
            end else begin
              ack_on_q <= 1'b0;
              cnt_q    <= '0;
              st_q     <= nxt_q;
              if (nxt_q == ST_TX) begin
                tx_q <= rd_byte[6:0];
                oe_q <= ~rd_byte[7];
              end else begin
                oe_q <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 3'd1;
              if (last_bit) st_q <= ST_TXEND;
            end else if (scl_fall) begin
              oe_q <= ~tx_q[6];
              tx_q <= {tx_q[5:0], 1'b0};
            end
          end
          ST_TXEND: if (scl_fall) begin
            oe_q <= 1'b0;  // free SDA for master ACK/NACK
            st_q <= ST_MACK;
          end
          ST_MACK: if (scl_rise) st_q <= sda_s ? ST_IDLE : ST_TXLOAD;
          ST_TXLOAD: if (scl_fall) begin
            tx_q  <= rd_byte[6:0];
            oe_q  <= ~rd_byte[7];
            cnt_q <= '0;
            st_q  <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign wr_en_o    = wr_en_q;
  assign wr_idx_o   = ptr_q[IDX_W-1:0];
  assign wr_data_o  = wr_data_q;
  assign gc_reset_o = gc_q;
  assign hs_mode_o  = hs_q;
endmodule

// File: rtl/tws_ptr_slave_chk.sv
module tws_ptr_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_i,
  input logic stop_i,
  input logic sda_oe_o,
  input logic hs_mode_o,
  input logic gc_reset_o,
  input logic wr_en_o
);
  p_sda_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

  p_wr_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  p_gc_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_reset_o |=> !gc_reset_o);

  p_hs_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !hs_mode_o);

  p_rstart_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_o);

  p_stop_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);
endmodule

bind tws_ptr_slave tws_ptr_slave_chk u_chk (
  .clk_i, .rst_ni, .scl_s(scl_s), .start_i(start_evt), .stop_i(stop_evt),
  .sda_oe_o, .hs_mode_o, .gc_reset_o, .wr_en_o
);

// File: tb/tb_tws_ptr_slave.sv
module tb_tws_ptr_slave;
  localparam int          QTR   = 8;
  localparam logic [31:0] INIT  = 32'hC3_96_5A_A5;
  localparam logic [2:0]  STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_en, gc_rst, hs;
  logic [1:0] wr_idx;
  logic [7:0] wr_data;
  logic sda_line;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tws_ptr_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel_i(STRAP), .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .gc_reset_o(gc_rst), .hs_mode_o(hs)
  );

  int vec = 0, err = 0, gc_cnt = 0;
  bit done = 1'b0;
  logic [7:0] m_regs [4];
  logic [7:0] m_ptr;
  logic [9:0] got_wr[$], exp_wr[$];

  always @(negedge clk) begin
    if (wr_en) got_wr.push_back({wr_idx, wr_data});
    if (gc_rst) gc_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (QTR) @(posedge clk);
    #1;
  endtask

  task automatic bit_c(input logic mb, input logic exp_oe, input string tag);
    scl_m = 1'b0; q();
    sda_m = mb;   q();
    scl_m = 1'b1; q();
    chk(tag, int'(sda_oe), int'(exp_oe));
    q();
  endtask

  task automatic start_c();
    scl_m = 1'b0; q();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    sda_m = 1'b0; q();
  endtask

  task automatic stop_c();
    scl_m = 1'b0; q();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) bit_c(b[i], 1'b0, tag);
    bit_c(1'b1, exp_ack, tag);
  endtask

  task automatic read_byte(input logic [7:0] e, input logic mack, input string tag);
    for (int i = 7; i >= 0; i--) bit_c(1'b1, ~e[i], tag);
    bit_c(~mack, 1'b0, tag);
  endtask

  function automatic logic [7:0] m_val();
    return (m_ptr < 8'd4) ? m_regs[m_ptr[1:0]] : 8'h00;
  endfunction

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1110, STRAP, rd};
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 4; k++) m_regs[k] = INIT[k*8 +: 8];
    m_ptr = 8'h00;
  endtask

  task automatic check_wr(input string tag);
    chk({tag, " write count"}, got_wr.size(), exp_wr.size());
    if (got_wr.size() == exp_wr.size())
      foreach (exp_wr[k]) chk({tag, " write event"}, int'(got_wr[k]), int'(exp_wr[k]));
    got_wr.delete();
    exp_wr.delete();
  endtask

  task automatic wr_txn(input logic [7:0] p, input int nd, input logic [7:0] d0,
                        input logic [7:0] d1, input string tag);
    start_c();
    send_byte(dev(1'b0), 1'b1, tag);
    send_byte(p, 1'b1, tag);
    m_ptr = p;
    for (int k = 0; k < nd; k++) begin
      logic [7:0] d;
      d = (k == 0) ? d0 : d1;
      send_byte(d, 1'b1, tag);
      if (m_ptr < 8'd4) begin
        m_regs[m_ptr[1:0]] = d;
        exp_wr.push_back({m_ptr[1:0], d});
      end
    end
    stop_c();
    check_wr(tag);
  endtask

  task automatic rd_txn(input int n, input string tag);
    start_c();
    send_byte(dev(1'b1), 1'b1, tag);
    for (int k = 0; k < n; k++) read_byte(m_val(), k < n - 1, tag);
    stop_c();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      err++;
      vec++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (5) @(posedge clk);
    #1;
    chk("R1 sda_oe reset", int'(sda_oe), 0);
    chk("R1 hs reset", int'(hs), 0);
    chk("R1 gc reset", int'(gc_rst), 0);
    chk("R1 wr_en reset", int'(wr_en), 0);
    rst_n = 1'b1;
    q();
    chk("R2 idle release", int'(sda_oe), 0);
    rd_txn(1, "R1 pointer zero reads reg0");

    wr_txn(8'd1, 1, 8'h3C, 8'h00, "R4 write reg1");
    rd_txn(1, "R6 read reg1");
    rd_txn(3, "R6 repeated reads keep pointer");

    start_c();
    send_byte(dev(1'b0), 1'b1, "R5 ptr-only addr");
    send_byte(8'd2, 1'b1, "R5 ptr-only ptr");
    m_ptr = 8'd2;
    stop_c();
    check_wr("R5 no write");
    rd_txn(1, "R5 read after ptr-only");

    start_c();
    send_byte({4'b1110, 3'b100, 1'b0}, 1'b0, "R3 wrong addr nack");
    send_byte(8'h01, 1'b0, "R3 ignored byte");
    send_byte(8'hFF, 1'b0, "R3 ignored byte");
    stop_c();
    check_wr("R3 no write");
    rd_txn(1, "R3 pointer kept");

    wr_txn(8'd7, 1, 8'h55, 8'h00, "R7 out-of-range write");
    rd_txn(1, "R7 out-of-range reads zero");
    wr_txn(8'd3, 2, 8'h11, 8'h22, "R4 two bytes same reg");
    rd_txn(1, "R4 last byte kept");

    start_c();
    send_byte(dev(1'b0), 1'b1, "R10 addr");
    send_byte(8'd0, 1'b1, "R10 ptr");
    m_ptr = 8'd0;
    start_c();
    send_byte(dev(1'b1), 1'b1, "R10 rs addr");
    read_byte(m_val(), 1'b0, "R10 read after rs");
    stop_c();
    start_c();
    send_byte(dev(1'b0), 1'b1, "R10 addr");
    send_byte(8'd3, 1'b1, "R10 ptr");
    m_ptr = 8'd3;
    bit_c(1'b1, 1'b0, "R10 partial");
    bit_c(1'b0, 1'b0, "R10 partial");
    bit_c(1'b1, 1'b0, "R10 partial");
    bit_c(1'b0, 1'b0, "R10 partial");
    start_c();
    send_byte(dev(1'b1), 1'b1, "R10 rs addr");
    read_byte(m_val(), 1'b0, "R10 reg3 unchanged");
    stop_c();
    check_wr("R10 aborted byte");

    start_c();
    send_byte(8'h0D, 1'b0, "R9 hs code nack");
    chk("R9 hs set", int'(hs), 1);
    start_c();
    chk("R9 hs after rs", int'(hs), 1);
    send_byte(dev(1'b0), 1'b1, "R9 addr in hs");
    send_byte(8'd1, 1'b1, "R9 ptr in hs");
    send_byte(8'h99, 1'b1, "R9 data in hs");
    m_ptr = 8'd1;
    m_regs[1] = 8'h99;
    exp_wr.push_back({2'd1, 8'h99});
    chk("R9 hs before stop", int'(hs), 1);
    stop_c();
    chk("R9 hs cleared", int'(hs), 0);
    chk("R11 released", int'(sda_oe), 0);
    check_wr("R9 write in hs");

    start_c();
    send_byte(8'h01, 1'b0, "R8 gc read nack");
    stop_c();
    start_c();
    send_byte(8'h00, 1'b1, "R8 gc addr");
    send_byte(8'h04, 1'b1, "R8 other cmd");
    stop_c();
    chk("R8 no reset pulse", gc_cnt, 0);
    rd_txn(1, "R8 other cmd no effect");
    start_c();
    send_byte(8'h00, 1'b1, "R8 gc addr");
    send_byte(8'h06, 1'b1, "R8 reset cmd");
    stop_c();
    chk("R8 reset pulse", gc_cnt, 1);
    model_reset();
    rd_txn(1, "R8 pointer restored");
    start_c();
    send_byte(dev(1'b0), 1'b1, "R8 ptr-only");
    send_byte(8'd1, 1'b1, "R8 ptr-only");
    m_ptr = 8'd1;
    stop_c();
    rd_txn(1, "R8 reg1 restored");
    check_wr("R8 no writes");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule